// File: doc/BRIEF.md
# UART Channel Mode Data Router

This block sits between the host side of a serial port, the byte-level receiver of the line, a receive FIFO it owns, and an external transmit FIFO. A two-bit channel mode decides where each byte goes. Bytes written by the host can head for the transmitter or loop straight back into the receive FIFO. Bytes from the line can be stored for the host, sent back out, or both. A control register gates each direction with an enable/disable pair and carries self-clearing flush commands. The block also reports overruns, turns a detected line break into a zero byte, and raises an inactivity event when no byte has arrived for four character times.

The host uses single-cycle strobes. `host_wr` offers a byte to the data register. `host_rd` pops one received byte, which appears on `rd_data` one cycle later. `ctrl_wr` writes the control register, and its new value governs routing from the next cycle on. The transmit FIFO port is valid/ready. `tx_push_valid` never depends on `tx_push_ready`, and a byte moves only in a cycle where both are high. The offer lasts a single cycle: when ready is low the byte is not kept but dropped, and the drop is reported as an overrun. The line input is a valid-only strobe with no ready, because a serial receiver cannot be stalled. Back-pressure from a full receive FIFO therefore shows up as a drop plus an overrun event.

Top module: `uart_chmode_router`

## Requirements
- R1: With `chan_mode` at 0 (normal) a line byte goes to the RX FIFO only. At 1 (echo) it goes to both the RX FIFO and the TX push port. At 3 (remote loopback) it goes to the TX push port only. At 2 (local loopback) it is discarded.
- R2: A host data write goes to the TX push port in mode 0 and into the RX FIFO in mode 2. In modes 1 and 3 it is discarded.
- R3: The receive direction (RX FIFO pushes and pops) works only while control bit 2 is 1 and control bit 3 is 0. The transmit direction works only while control bit 4 is 1 and bit 5 is 0. A set disable bit wins over a set enable bit.
- R4: After reset `ctrl_q` reads 0x128 (both directions disabled, bit 8 set). A control write stores bits 8:2 as written.
- R5: Writing control bit 0 empties the RX FIFO, and writing bit 1 pulses `tx_flush` in the same cycle. Both bits always read back as 0.
- R6: A byte bound for a full RX FIFO is discarded, the stored bytes are left intact, and `ovr_evt` is high for one cycle after the attempt.
- R7: A TX push offered while `tx_push_ready` is low is discarded, and `ovr_evt` is high for one cycle after it.
- R8: A `brk_pulse` pushes 0x00 into the RX FIFO when the receive direction is enabled, whatever the mode. A line or host byte bound for the RX FIFO in the same cycle is discarded.
- R9: A `host_rd` that finds the RX FIFO empty, or the receive direction disabled, returns 0 on `rd_data` and removes nothing.
- R10: The RX FIFO returns bytes in arrival order and holds exactly DEPTH bytes.
- R11: `tmo_evt` pulses for one cycle exactly 4*`char_cycles` clock edges after the edge on which the latest byte entered the RX FIFO. Each new byte restarts the count.
- R12: With `tmo_cfg` equal to 0 the timeout expires without raising `tmo_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_mode | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control write value |
| ctrl_q | output | 9 | Control register readback |
| host_wr | input | 1 | Host data write strobe |
| host_wdata | input | 8 | Host data byte |
| host_rd | input | 1 | Host data read strobe |
| rd_data | output | 8 | Byte returned by the latest read |
| line_valid | input | 1 | Received-byte strobe from the line |
| line_data | input | 8 | Received byte |
| brk_pulse | input | 1 | Line break detected |
| tx_push_valid | output | 1 | TX FIFO push offer |
| tx_push_data | output | 8 | TX FIFO push byte |
| tx_push_ready | input | 1 | TX FIFO can accept |
| tx_flush | output | 1 | Empty the TX FIFO |
| char_cycles | input | CHAR_W | Character time in clock cycles |
| tmo_cfg | input | 8 | Timeout setting; zero suppresses the event |
| ovr_evt | output | 1 | Overrun event pulse |
| tmo_evt | output | 1 | Receive inactivity event pulse |

## Verification
The bench builds the block with DEPTH set to 4. With that depth, filling the FIFO, the overrun drop and wrap of the read and write pointers each take only a handful of bytes. CHAR_W stays at its default, and `char_cycles` is set to 3, so a full timeout window is twelve edges. That is short enough to measure edge by edge and to show a restart partway through. The vector loop covers every pairing of mode and source.

// File: rtl/uart_router_pkg.sv
package uart_router_pkg;

  typedef enum logic [1:0] {
    CH_NORMAL    = 2'd0,
    CH_ECHO      = 2'd1,
    CH_LOCAL_LB  = 2'd2,
    CH_REMOTE_LB = 2'd3
  } chan_mode_e;

  localparam int CTRL_W       = 9;
  localparam int CB_RX_FLUSH  = 0;
  localparam int CB_TX_FLUSH  = 1;
  localparam int CB_RX_ON     = 2;
  localparam int CB_RX_OFF    = 3;
  localparam int CB_TX_ON     = 4;
  localparam int CB_TX_OFF    = 5;
  localparam logic [CTRL_W-1:0] CTRL_RST_VAL = 9'h128;

  typedef struct packed {
    logic       vld;
    logic [7:0] data;
  } byte_slot_t;

endpackage

// File: rtl/uart_ctrl_reg.sv
module uart_ctrl_reg
  import uart_router_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] q,
  output logic              rx_clr,
  output logic              tx_clr,
  output logic              rx_on,
  output logic              tx_on
);

  localparam logic [CTRL_W-1:0] SELF_CLR_MASK =
    CTRL_W'((1 << CB_RX_FLUSH) | (1 << CB_TX_FLUSH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CTRL_RST_VAL;
    else if (wr) q <= wdata & ~SELF_CLR_MASK;
  end

  assign rx_clr = wr && wdata[CB_RX_FLUSH];
  assign tx_clr = wr && wdata[CB_TX_FLUSH];
  assign rx_on  = q[CB_RX_ON] && !q[CB_RX_OFF];
  assign tx_on  = q[CB_TX_ON] && !q[CB_TX_OFF];

endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uart_chmode_route.sv
module uart_chmode_route
  import uart_router_pkg::*;
(
  input  logic [1:0] chan_mode,
  input  logic       rx_on,
  input  logic       tx_on,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic       host_rd,
  input  logic       line_valid,
  input  logic [7:0] line_data,
  input  logic       brk_pulse,
  input  logic       rx_full,
  input  logic       rx_empty,
  input  logic       tx_ready,
  output logic       rx_push,
  output logic [7:0] rx_push_data,
  output logic       rx_pop,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       ovr
);

  chan_mode_e mode;
  byte_slot_t rx_cand, tx_cand;
  logic       line_to_rx, line_to_tx;

  assign mode       = chan_mode_e'(chan_mode);
  assign line_to_rx = (mode == CH_NORMAL) || (mode == CH_ECHO);
  assign line_to_tx = (mode == CH_ECHO) || (mode == CH_REMOTE_LB);

  always_comb begin
    rx_cand = '0;
    if (brk_pulse)                              rx_cand = '{vld: 1'b1, data: 8'h00};
    else if (line_valid && line_to_rx)          rx_cand = '{vld: 1'b1, data: line_data};
    else if (host_wr && mode == CH_LOCAL_LB)    rx_cand = '{vld: 1'b1, data: host_wdata};
  end

  always_comb begin
    tx_cand = '0;
    if (line_valid && line_to_tx)               tx_cand = '{vld: 1'b1, data: line_data};
    else if (host_wr && mode == CH_NORMAL)      tx_cand = '{vld: 1'b1, data: host_wdata};
  end

  assign rx_push      = rx_cand.vld && rx_on && !rx_full;
  assign rx_push_data = rx_cand.data;
  assign rx_pop       = host_rd && rx_on && !rx_empty;
  assign tx_valid     = tx_cand.vld && tx_on;
  assign tx_data      = tx_cand.data;
  assign ovr          = (rx_cand.vld && rx_on && rx_full) || (tx_valid && !tx_ready);

endmodule

// File: rtl/uart_idle_timer.sv
module uart_idle_timer #(
  parameter int CHAR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CHAR_W-1:0] char_cycles,
  input  logic              report_en,
  output logic              expire
);

  localparam int CNT_W = CHAR_W + 2;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (restart) begin
        cnt <= {char_cycles, 2'b00};
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) expire <= report_en;
      end
    end
  end

endmodule

// File: rtl/uart_chmode_router.sv
module uart_chmode_router
  import uart_router_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CHAR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        chan_mode,
  input  logic              ctrl_wr,
  input  logic [8:0]        ctrl_wdata,
  output logic [8:0]        ctrl_q,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  input  logic              host_rd,
  output logic [7:0]        rd_data,
  input  logic              line_valid,
  input  logic [7:0]        line_data,
  input  logic              brk_pulse,
  output logic              tx_push_valid,
  output logic [7:0]        tx_push_data,
  input  logic              tx_push_ready,
  output logic              tx_flush,
  input  logic [CHAR_W-1:0] char_cycles,
  input  logic [7:0]        tmo_cfg,
  output logic              ovr_evt,
  output logic              tmo_evt
);

  logic       rx_clr, rx_on, tx_on;
  logic       rx_push, rx_pop, rx_full, rx_empty, ovr_now;
  logic [7:0] rx_push_data, rx_head;

  uart_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (ctrl_wr),
    .wdata  (ctrl_wdata),
    .q      (ctrl_q),
    .rx_clr (rx_clr),
    .tx_clr (tx_flush),
    .rx_on  (rx_on),
    .tx_on  (tx_on)
  );

  uart_chmode_route u_route (
    .chan_mode    (chan_mode),
    .rx_on        (rx_on),
    .tx_on        (tx_on),
    .host_wr      (host_wr),
    .host_wdata   (host_wdata),
    .host_rd      (host_rd),
    .line_valid   (line_valid),
    .line_data    (line_data),
    .brk_pulse    (brk_pulse),
    .rx_full      (rx_full),
    .rx_empty     (rx_empty),
    .tx_ready     (tx_push_ready),
    .rx_push      (rx_push),
    .rx_push_data (rx_push_data),
    .rx_pop       (rx_pop),
    .tx_valid     (tx_push_valid),
    .tx_data      (tx_push_data),
    .ovr          (ovr_now)
  );

  uart_rx_store #(.DEPTH(DEPTH), .DW(8)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rx_clr),
    .push      (rx_push),
    .push_data (rx_push_data),
    .pop       (rx_pop),
    .head      (rx_head),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  uart_idle_timer #(.CHAR_W(CHAR_W)) u_tmo (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (rx_push && !rx_clr),
    .char_cycles (char_cycles),
    .report_en   (tmo_cfg != 8'h00),
    .expire      (tmo_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      ovr_evt <= 1'b0;
    end else begin
      ovr_evt <= ovr_now;
      if (host_rd) rd_data <= (rx_pop && !rx_clr) ? rx_head : 8'h00;
    end
  end

endmodule

// File: rtl/uart_router_checker.sv
module uart_router_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] chan_mode,
  input logic       ctrl_wr,
  input logic [8:0] ctrl_wdata,
  input logic [8:0] ctrl_q,
  input logic       host_rd,
  input logic       rx_empty,
  input logic       rx_clr,
  input logic [7:0] rd_data,
  input logic       tx_push_valid,
  input logic       tx_push_ready,
  input logic       ovr_evt,
  input logic       tmo_evt,
  input logic [7:0] tmo_cfg
);

  AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_q == ($past(ctrl_wdata) & 9'h1FC)); // R5

  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_valid |-> (ctrl_q[4] && !ctrl_q[5])); // R3

  AST_LOCAL_LB_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mode == 2'd2) |-> !tx_push_valid); // R1

  AST_TX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_valid && !tx_push_ready) |=> ovr_evt); // R7

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && rx_empty) |=> rd_data == 8'h00); // R9

  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> rx_empty); // R5

  AST_TMO_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |-> $past(tmo_cfg != 8'h00)); // R12

endmodule

bind uart_chmode_router uart_router_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .chan_mode     (chan_mode),
  .ctrl_wr       (ctrl_wr),
  .ctrl_wdata    (ctrl_wdata),
  .ctrl_q        (ctrl_q),
  .host_rd       (host_rd),
  .rx_empty      (rx_empty),
  .rx_clr        (rx_clr),
  .rd_data       (rd_data),
  .tx_push_valid (tx_push_valid),
  .tx_push_ready (tx_push_ready),
  .ovr_evt       (ovr_evt),
  .tmo_evt       (tmo_evt),
  .tmo_cfg       (tmo_cfg)
);

// File: tb/uart_chmode_router_tb_top.sv
`timescale 1ns/1ps
module uart_chmode_router_tb_top;

  localparam int DEPTH  = 4;
  localparam int CHAR_W = 16;

  // {mode[1:0], from_host, expect_rx, expect_tx}
  localparam logic [4:0] ROUTE_TBL [8] = '{
    5'b00_0_10, 5'b00_1_01, 5'b01_0_11, 5'b01_1_00,
    5'b10_0_00, 5'b10_1_10, 5'b11_0_01, 5'b11_1_00
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        chan_mode = 2'd0;
  logic              ctrl_wr = 1'b0;
  logic [8:0]        ctrl_wdata = '0;
  logic [8:0]        ctrl_q;
  logic              host_wr = 1'b0;
  logic [7:0]        host_wdata = '0;
  logic              host_rd = 1'b0;
  logic [7:0]        rd_data;
  logic              line_valid = 1'b0;
  logic [7:0]        line_data = '0;
  logic              brk_pulse = 1'b0;
  logic              tx_push_valid;
  logic [7:0]        tx_push_data;
  logic              tx_push_ready = 1'b1;
  logic              tx_flush;
  logic [CHAR_W-1:0] char_cycles = '0;
  logic [7:0]        tmo_cfg = '0;
  logic              ovr_evt;
  logic              tmo_evt;

  int   errs = 0;
  int   checks = 0;
  logic done = 1'b0;
  logic       cap_txv;
  logic [7:0] cap_txd;
  logic [7:0] rbyte;

  always #4 clk = ~clk;

  uart_chmode_router #(.DEPTH(DEPTH), .CHAR_W(CHAR_W)) dut_i (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic ctrl_write(input logic [8:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic line_byte(input logic [7:0] b, input logic brk);
    @(negedge clk); line_valid = 1'b1; line_data = b; brk_pulse = brk;
    #1 cap_txv = tx_push_valid; cap_txd = tx_push_data;
    @(negedge clk); line_valid = 1'b0; brk_pulse = 1'b0;
  endtask

  task automatic host_byte(input logic [7:0] b);
    @(negedge clk); host_wr = 1'b1; host_wdata = b;
    #1 cap_txv = tx_push_valid; cap_txd = tx_push_data;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic host_read(output logic [7:0] b);
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; b = rd_data;
  endtask

  task automatic measure_tmo(input int expect_edges);
    int seen = 0;
    for (int k = 1; k <= expect_edges + 4; k++) begin
      @(negedge clk);
      if (tmo_evt && seen == 0) seen = k;
    end
    chk(seen == expect_edges, "R11 timeout edge count", seen, expect_edges);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    chk(ctrl_q == 9'h128, "R4 ctrl reset", ctrl_q, 9'h128);
    chk(!ovr_evt && !tmo_evt && !tx_push_valid, "R4 idle outputs", {ovr_evt, tmo_evt, tx_push_valid}, 0);

    // R3/R9: disabled paths
    host_byte(8'h11);
    chk(!cap_txv, "R3 tx disabled after reset", cap_txv, 0);
    line_byte(8'h22, 1'b0);
    host_read(rbyte);
    chk(rbyte == 8'h00, "R9 read while rx disabled", rbyte, 0);
    ctrl_write(9'h014);
    host_read(rbyte);
    chk(rbyte == 8'h00, "R3 byte not stored while disabled", rbyte, 0);

    // R5 self-clearing bits
    ctrl_write(9'h017);
    chk(ctrl_q == 9'h014, "R5 flush bits read zero", ctrl_q, 9'h014);

    // R1/R2 routing table
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      b = 8'h40 + 8'(i);
      ctrl_write(9'h017);
      chan_mode = ROUTE_TBL[i][4:3];
      if (ROUTE_TBL[i][2]) host_byte(b); else line_byte(b, 1'b0);
      chk(cap_txv == ROUTE_TBL[i][0], ROUTE_TBL[i][2] ? "R2 tx route" : "R1 tx route",
          cap_txv, ROUTE_TBL[i][0]);
      if (cap_txv) chk(cap_txd == b, "R1 tx data", cap_txd, b);
      host_read(rbyte);
      chk(rbyte == (ROUTE_TBL[i][1] ? b : 8'h00), ROUTE_TBL[i][2] ? "R2 rx route" : "R1 rx route",
          rbyte, ROUTE_TBL[i][1] ? b : 8'h00);
    end

    // R3 disable wins
    chan_mode = 2'd0;
    ctrl_write(9'h01D);
    line_byte(8'h33, 1'b0);
    ctrl_write(9'h014);
    host_read(rbyte);
    chk(rbyte == 8'h00, "R3 rx disable wins", rbyte, 0);
    ctrl_write(9'h034);
    host_byte(8'h34);
    chk(!cap_txv, "R3 tx disable wins", cap_txv, 0);

    // R6/R10 fill, overrun, order
    ctrl_write(9'h017);
    for (int i = 0; i < DEPTH; i++) begin
      line_byte(8'hA0 + 8'(i), 1'b0);
      chk(!ovr_evt, "R10 no overrun below depth", ovr_evt, 0);
    end
    line_byte(8'hAF, 1'b0);
    chk(ovr_evt, "R6 rx overrun", ovr_evt, 1);
    for (int i = 0; i < DEPTH; i++) begin
      host_read(rbyte);
      chk(rbyte == 8'hA0 + 8'(i), "R10 fifo order", rbyte, 8'hA0 + 8'(i));
    end
    host_read(rbyte);
    chk(rbyte == 8'h00, "R9 empty read zero", rbyte, 0);

    // R7 tx overrun
    tx_push_ready = 1'b0;
    host_byte(8'h5A);
    chk(cap_txv, "R7 tx offered", cap_txv, 1);
    chk(ovr_evt, "R7 tx overrun", ovr_evt, 1);
    tx_push_ready = 1'b1;
    host_byte(8'h5B);
    chk(!ovr_evt, "R7 no overrun when ready", ovr_evt, 0);

    // R8 break
    line_byte(8'h77, 1'b0);
    line_byte(8'h55, 1'b1);
    host_read(rbyte);
    chk(rbyte == 8'h77, "R8 byte before break", rbyte, 8'h77);
    host_read(rbyte);
    chk(rbyte == 8'h00, "R8 break byte", rbyte, 0);
    line_byte(8'h66, 1'b0);
    host_read(rbyte);
    chk(rbyte == 8'h66, "R8 simultaneous line byte dropped", rbyte, 8'h66);

    // R5 rx flush
    line_byte(8'h81, 1'b0);
    line_byte(8'h82, 1'b0);
    ctrl_write(9'h015);
    host_read(rbyte);
    chk(rbyte == 8'h00, "R5 rx flush", rbyte, 0);

    // R11 timeout and restart
    char_cycles = 16'd3;
    tmo_cfg = 8'd1;
    ctrl_write(9'h015);
    line_byte(8'h91, 1'b0);
    measure_tmo(12);
    line_byte(8'h92, 1'b0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!tmo_evt, "R11 no early timeout", tmo_evt, 0);
    end
    line_byte(8'h93, 1'b0);
    measure_tmo(12);

    // R12 suppressed timeout
    tmo_cfg = 8'd0;
    ctrl_write(9'h015);
    line_byte(8'h94, 1'b0);
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (tmo_evt) seen = 1;
      end
      chk(seen == 0, "R12 timeout suppressed", seen, 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule